// File: doc/BRIEF.md
# Sync-Pulse Command Receiver

This block receives downstream commands that a controller sends to a sensor by modulating its periodic sync pulses. Each qualified sync pulse carries one bit. The block qualifies raw comparator pulses by their length and hunts for a start pattern. It then assembles a short or a long command frame and checks the frame's CRC and its destination address. Each accepted command goes to the response generator as a one-cycle strobe with the decoded address, command code and data.

If the controller stops sending sync pulses in the middle of a frame, the frame is dropped. A framing-error flag is then raised at the next sync pulse, so that the response generator can answer it with a framing-error reply. The block also gates entry into programming mode. Entry needs a minimum run of sync pulses and then the entry command, and both must fall inside a fixed window after reset.

Top module: `synccmd_rx`

## Requirements
- R1: A sync pulse counts only if `cmp_hi` stays high for more than SYNC_LIM consecutive clocks (default 4, so at least 5 clocks). Its bit is the value of `bit_in` on the clock where the pulse qualifies. A shorter pulse is ignored completely.
- R2: A frame starts with at least START_ZEROS (3) qualified 0-bits followed by a 1-bit. A 1-bit after fewer zeros starts nothing.
- R3: After the start 1-bit, the frame body is sent MSB first in this order:
  - a length bit: 0 means short, 1 means long;
  - a 3-bit address;
  - a 4-bit command code;
  - the data: 4 bits for a short frame, 12 bits for a long frame;
  - a 3-bit CRC.
  An accepted frame gives a one-clock `cmd_vld` pulse with the fields. Short data is zero-extended to 12 bits.
- R4: The CRC is a serial CRC-3 with polynomial x^3+x+1 and seed 3'b111. It runs over the address, code and data bits in transmit order and is sent MSB first. A frame whose CRC does not match produces no `cmd_vld`.
- R5: Only the device address 3'b001 and the broadcast address 3'b111 are accepted. A frame to any other address produces no `cmd_vld`.
- R6: While a frame body is being received, a qualified sync that follows the previous one by GAP_BITS*BIT_CYC clocks (128) or fewer keeps the frame alive. A gap of 129 or more clocks drops the frame, and it produces no `cmd_vld`.
- R7: After a dropped frame, `frm_err` rises one clock after the next qualified sync, and not before. It stays high until the next frame start, which clears it.
- R8: `prog_mode` is set when an accepted command with code 4'hA arrives while two conditions hold:
  - the entry window is still open (PME_WIN_CYC = 3000 clocks after reset);
  - at least 31 qualified syncs were counted while the receiver was idle inside the window. The start bits of the entry frame itself count.
  Once set, `prog_mode` stays set until reset.
- R9: With only 30 counted idle syncs, the entry command is decoded normally but `prog_mode` stays 0.
- R10: After the window closes, sync pulses are not counted and the entry command does not set `prog_mode`. Normal decoding continues.
- R11: While reset is asserted, `cmd_vld`, `frm_err`, `prog_mode` and all field outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_hi | input | 1 | Sync comparator output, high during a pulse |
| bit_in | input | 1 | Command bit carried by the current sync period |
| cmd_vld | output | 1 | One-clock strobe for an accepted command |
| cmd_long | output | 1 | Accepted frame was long |
| cmd_addr | output | 3 | Decoded address |
| cmd_code | output | 4 | Decoded command code |
| cmd_data | output | 12 | Decoded data, zero-extended for short frames |
| frm_err | output | 1 | Framing error pending for the response generator |
| prog_mode | output | 1 | Programming mode entered |

## Verification
Two things can happen on the same clock: the gap timer reaches its limit, and a qualified sync arrives. The bench provokes this by stretching one body bit period to exactly 128 clocks, and in a second frame to 129. At 128 the sync must win: the frame completes and `frm_err` stays low. At 129 the frame must be dropped with no `cmd_vld`, and `frm_err` must rise with the following sync.

// File: rtl/synccmd_pkg.sv
package synccmd_pkg;
  typedef enum logic [0:0] {ST_HUNT, ST_BODY} rx_st_e;

  localparam int CRC_W = 3;
  localparam logic [CRC_W-1:0] CRC_SEED = 3'b111;

  // one serial step of the x^3+x+1 CRC
  function automatic logic [CRC_W-1:0] crc3_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[2] ^ b;
    return {c[1], c[0] ^ fb, fb};
  endfunction
endpackage

// File: rtl/synccmd_sync_qual.sv
module synccmd_sync_qual #(
  parameter int SYNC_LIM = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_hi,
  input  logic bit_in,
  output logic sync_vld,
  output logic sync_bit
);
  localparam int CW = $clog2(SYNC_LIM + 2);
  localparam logic [CW-1:0] SAT = CW'(SYNC_LIM + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          hit;
  logic          stb_q, bit_q;

  always_comb begin
    cnt_d = '0;
    if (cmp_hi) cnt_d = (cnt_q == SAT) ? cnt_q : cnt_q + 1'b1;
    hit = cmp_hi && (cnt_q == CW'(SYNC_LIM));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      stb_q <= hit;
      if (hit) bit_q <= bit_in;
    end
  end

  assign sync_vld = stb_q;
  assign sync_bit = bit_q;
endmodule

// File: rtl/synccmd_frame_rx.sv
module synccmd_frame_rx
  import synccmd_pkg::*;
#(
  parameter int BIT_CYC = 32,
  parameter int GAP_BITS = 4,
  parameter int START_ZEROS = 3,
  parameter int ADDR_W = 3,
  parameter int CODE_W = 4,
  parameter int SDATA_W = 4,
  parameter int LDATA_W = 12,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 3'b001,
  parameter logic [ADDR_W-1:0] BCAST_ADDR = 3'b111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_vld,
  input  logic               sync_bit,
  output logic               cmd_vld,
  output logic               cmd_long,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic [CODE_W-1:0]  cmd_code,
  output logic [LDATA_W-1:0] cmd_data,
  output logic               frm_err,
  output logic               rx_idle
);
  localparam int SLEN = 1 + ADDR_W + CODE_W + SDATA_W + CRC_W;
  localparam int LLEN = 1 + ADDR_W + CODE_W + LDATA_W + CRC_W;
  localparam int SRW  = LLEN - 2;
  localparam int BCW  = $clog2(LLEN + 1);
  localparam int WIN  = GAP_BITS * BIT_CYC;
  localparam int TW   = $clog2(WIN);
  localparam int ZW   = $clog2(START_ZEROS + 1);

  rx_st_e             st_q, st_d;
  logic [ZW-1:0]      zcnt_q, zcnt_d;
  logic [BCW-1:0]     bcnt_q, bcnt_d;
  logic               long_q, long_d;
  logic [SRW-1:0]     sr_q, sr_d;
  logic [CRC_W-1:0]   crc_q, crc_d;
  logic [TW-1:0]      tmr_q, tmr_d;
  logic               pend_q, pend_d, err_q, err_d;
  logic               vld_q, vld_d, olong_q, olong_d;
  logic [ADDR_W-1:0]  oaddr_q, oaddr_d;
  logic [CODE_W-1:0]  ocode_q, ocode_d;
  logic [LDATA_W-1:0] odata_q, odata_d;

  logic [SRW:0]       nv;
  logic               cur_long, last_bit, in_crc, crc_ok, addr_ok;
  logic [ADDR_W-1:0]  f_addr;
  logic [CODE_W-1:0]  f_code;
  logic [LDATA_W-1:0] f_data;

  // field view of the frame including the bit on this sync
  always_comb begin
    nv       = {sr_q, sync_bit};
    cur_long = (bcnt_q == '0) ? sync_bit : long_q;
    last_bit = bcnt_q == (cur_long ? BCW'(LLEN - 1) : BCW'(SLEN - 1));
    in_crc   = (bcnt_q != '0) && (bcnt_q <= (cur_long ? BCW'(LLEN - 1 - CRC_W) : BCW'(SLEN - 1 - CRC_W)));
    if (cur_long) begin
      f_addr = nv[CRC_W + LDATA_W + CODE_W +: ADDR_W];
      f_code = nv[CRC_W + LDATA_W +: CODE_W];
      f_data = nv[CRC_W +: LDATA_W];
    end else begin
      f_addr = nv[CRC_W + SDATA_W + CODE_W +: ADDR_W];
      f_code = nv[CRC_W + SDATA_W +: CODE_W];
      f_data = {{(LDATA_W - SDATA_W){1'b0}}, nv[CRC_W +: SDATA_W]};
    end
    crc_ok  = nv[CRC_W-1:0] == crc_q;
    addr_ok = (f_addr == DEV_ADDR) || (f_addr == BCAST_ADDR);
  end

  always_comb begin
    st_d = st_q;  zcnt_d = zcnt_q;  bcnt_d = bcnt_q;  long_d = long_q;
    sr_d = sr_q;  crc_d = crc_q;    tmr_d = tmr_q;
    pend_d = pend_q;  err_d = err_q;
    vld_d = 1'b0;  olong_d = olong_q;  oaddr_d = oaddr_q;
    ocode_d = ocode_q;  odata_d = odata_q;
    case (st_q)
      ST_HUNT: begin
        if (sync_vld) begin
          if (pend_q) begin
            err_d  = 1'b1;
            pend_d = 1'b0;
            zcnt_d = '0;
          end else if (!sync_bit) begin
            if (zcnt_q != ZW'(START_ZEROS)) zcnt_d = zcnt_q + 1'b1;
          end else if (zcnt_q == ZW'(START_ZEROS)) begin
            st_d   = ST_BODY;
            bcnt_d = '0;
            tmr_d  = '0;
            crc_d  = CRC_SEED;
            err_d  = 1'b0;
            zcnt_d = '0;
          end else begin
            zcnt_d = '0;
          end
        end
      end
      default: begin
        if (sync_vld) begin
          tmr_d  = '0;
          sr_d   = nv[SRW-1:0];
          bcnt_d = bcnt_q + 1'b1;
          if (bcnt_q == '0) long_d = sync_bit;
          if (in_crc) crc_d = crc3_step(crc_q, sync_bit);
          if (last_bit) begin
            st_d = ST_HUNT;
            if (crc_ok && addr_ok) begin
              vld_d   = 1'b1;
              olong_d = cur_long;
              oaddr_d = f_addr;
              ocode_d = f_code;
              odata_d = f_data;
            end
          end
        end else if (tmr_q == TW'(WIN - 1)) begin
          st_d   = ST_HUNT;
          pend_d = 1'b1;
          zcnt_d = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_HUNT;  zcnt_q <= '0;  bcnt_q <= '0;  long_q <= 1'b0;
      sr_q <= '0;  crc_q <= CRC_SEED;  tmr_q <= '0;
      pend_q <= 1'b0;  err_q <= 1'b0;
      vld_q <= 1'b0;  olong_q <= 1'b0;  oaddr_q <= '0;  ocode_q <= '0;  odata_q <= '0;
    end else begin
      st_q <= st_d;  zcnt_q <= zcnt_d;  bcnt_q <= bcnt_d;  long_q <= long_d;
      sr_q <= sr_d;  crc_q <= crc_d;  tmr_q <= tmr_d;
      pend_q <= pend_d;  err_q <= err_d;
      vld_q <= vld_d;  olong_q <= olong_d;  oaddr_q <= oaddr_d;  ocode_q <= ocode_d;  odata_q <= odata_d;
    end
  end

  assign cmd_vld  = vld_q;
  assign cmd_long = olong_q;
  assign cmd_addr = oaddr_q;
  assign cmd_code = ocode_q;
  assign cmd_data = odata_q;
  assign frm_err  = err_q;
  assign rx_idle  = (st_q == ST_HUNT);
endmodule

// File: rtl/synccmd_pme_gate.sv
module synccmd_pme_gate #(
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] PME_CODE = 4'hA,
  parameter int PME_MIN_SYNC = 31,
  parameter int PME_WIN_CYC = 3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_vld,
  input  logic              rx_idle,
  input  logic              acc_vld,
  input  logic [CODE_W-1:0] acc_code,
  output logic              prog_mode
);
  localparam int WW = $clog2(PME_WIN_CYC + 1);
  localparam int SW = $clog2(PME_MIN_SYNC + 1);

  logic [WW-1:0] wcnt_q, wcnt_d;
  logic [SW-1:0] scnt_q, scnt_d;
  logic          in_win, prog_q, prog_d;

  always_comb begin
    in_win = wcnt_q != WW'(PME_WIN_CYC);
    wcnt_d = in_win ? wcnt_q + 1'b1 : wcnt_q;
    scnt_d = scnt_q;
    if (in_win && sync_vld && rx_idle && (scnt_q != SW'(PME_MIN_SYNC)))
      scnt_d = scnt_q + 1'b1;
    prog_d = prog_q;
    if (acc_vld && (acc_code == PME_CODE) && in_win && (scnt_q == SW'(PME_MIN_SYNC)))
      prog_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      scnt_q <= '0;
      prog_q <= 1'b0;
    end else begin
      wcnt_q <= wcnt_d;
      scnt_q <= scnt_d;
      prog_q <= prog_d;
    end
  end

  assign prog_mode = prog_q;
endmodule

// File: rtl/synccmd_rx.sv
module synccmd_rx #(
  parameter int SYNC_LIM = 4,
  parameter int BIT_CYC = 32,
  parameter int GAP_BITS = 4,
  parameter int START_ZEROS = 3,
  parameter int ADDR_W = 3,
  parameter int CODE_W = 4,
  parameter int SDATA_W = 4,
  parameter int LDATA_W = 12,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 3'b001,
  parameter logic [ADDR_W-1:0] BCAST_ADDR = 3'b111,
  parameter logic [CODE_W-1:0] PME_CODE = 4'hA,
  parameter int PME_MIN_SYNC = 31,
  parameter int PME_WIN_CYC = 3000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmp_hi,
  input  logic               bit_in,
  output logic               cmd_vld,
  output logic               cmd_long,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic [CODE_W-1:0]  cmd_code,
  output logic [LDATA_W-1:0] cmd_data,
  output logic               frm_err,
  output logic               prog_mode
);
  logic sync_stb, sync_bit, rx_idle;

  synccmd_sync_qual #(.SYNC_LIM(SYNC_LIM)) u_qual (
    .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi), .bit_in(bit_in),
    .sync_vld(sync_stb), .sync_bit(sync_bit));

  synccmd_frame_rx #(
    .BIT_CYC(BIT_CYC), .GAP_BITS(GAP_BITS), .START_ZEROS(START_ZEROS),
    .ADDR_W(ADDR_W), .CODE_W(CODE_W), .SDATA_W(SDATA_W), .LDATA_W(LDATA_W),
    .DEV_ADDR(DEV_ADDR), .BCAST_ADDR(BCAST_ADDR)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .sync_vld(sync_stb), .sync_bit(sync_bit),
    .cmd_vld(cmd_vld), .cmd_long(cmd_long), .cmd_addr(cmd_addr),
    .cmd_code(cmd_code), .cmd_data(cmd_data), .frm_err(frm_err), .rx_idle(rx_idle));

  synccmd_pme_gate #(
    .CODE_W(CODE_W), .PME_CODE(PME_CODE), .PME_MIN_SYNC(PME_MIN_SYNC),
    .PME_WIN_CYC(PME_WIN_CYC)
  ) u_pme (
    .clk(clk), .rst_n(rst_n), .sync_vld(sync_stb), .rx_idle(rx_idle),
    .acc_vld(cmd_vld), .acc_code(cmd_code), .prog_mode(prog_mode));
endmodule

// File: rtl/synccmd_rx_chk.sv
module synccmd_rx_chk #(
  parameter int ADDR_W = 3,
  parameter int SDATA_W = 4,
  parameter int LDATA_W = 12,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 3'b001,
  parameter logic [ADDR_W-1:0] BCAST_ADDR = 3'b111,
  parameter int PME_WIN_CYC = 3000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sync_stb,
  input logic               cmd_vld,
  input logic               cmd_long,
  input logic [ADDR_W-1:0]  cmd_addr,
  input logic [LDATA_W-1:0] cmd_data,
  input logic               frm_err,
  input logic               prog_mode
);
  localparam int CCW = $clog2(PME_WIN_CYC + 3);
  logic [CCW-1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else if (cyc_q != CCW'(PME_WIN_CYC + 2)) cyc_q <= cyc_q + 1'b1;
  end

  AST_VLD_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n) cmd_vld |=> !cmd_vld); // R3
  AST_VLD_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n) cmd_vld |-> $past(sync_stb)); // R1
  AST_SHORT_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !cmd_long) |-> (cmd_data[LDATA_W-1:SDATA_W] == '0)); // R3
  AST_ADDR_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> ((cmd_addr == DEV_ADDR) || (cmd_addr == BCAST_ADDR))); // R5
  AST_ERR_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n) $rose(frm_err) |-> $past(sync_stb)); // R7
  AST_PROG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) prog_mode |=> prog_mode); // R8
  AST_PROG_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_mode) |-> (cyc_q <= CCW'(PME_WIN_CYC + 1))); // R10
endmodule

bind synccmd_rx synccmd_rx_chk #(
  .ADDR_W(ADDR_W), .SDATA_W(SDATA_W), .LDATA_W(LDATA_W),
  .DEV_ADDR(DEV_ADDR), .BCAST_ADDR(BCAST_ADDR), .PME_WIN_CYC(PME_WIN_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_stb(sync_stb), .cmd_vld(cmd_vld),
  .cmd_long(cmd_long), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
  .frm_err(frm_err), .prog_mode(prog_mode));

// File: tb/sim_synccmd_rx.sv
`timescale 1ns/1ps
module sim_synccmd_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_hi = 1'b0;
  logic bit_in = 1'b0;
  logic cmd_vld, cmd_long, frm_err, prog_mode;
  logic [2:0] cmd_addr;
  logic [3:0] cmd_code;
  logic [11:0] cmd_data;

  int n_chk = 0, n_bad = 0, n_vld = 0;
  logic cap_long;
  logic [2:0] cap_addr;
  logic [3:0] cap_code;
  logic [11:0] cap_data;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  synccmd_rx u0 (.clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi), .bit_in(bit_in),
    .cmd_vld(cmd_vld), .cmd_long(cmd_long), .cmd_addr(cmd_addr), .cmd_code(cmd_code),
    .cmd_data(cmd_data), .frm_err(frm_err), .prog_mode(prog_mode));

  always @(posedge clk) if (cmd_vld) begin
    n_vld <= n_vld + 1;
    cap_long <= cmd_long; cap_addr <= cmd_addr; cap_code <= cmd_code; cap_data <= cmd_data;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmp_hi = 1'b0; bit_in = 1'b0;
    repeat (4) @(negedge clk);
    check(cmd_vld == 0 && frm_err == 0 && prog_mode == 0 && cmd_data == 0 && cmd_addr == 0,
          "R11", "outputs in reset", {cmd_vld, frm_err, prog_mode}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(input bit b, input int hi, input int per);
    cmp_hi = 1'b1; bit_in = b;
    repeat (hi) @(negedge clk);
    cmp_hi = 1'b0; bit_in = 1'b0;
    repeat (per - hi) @(negedge clk);
  endtask

  function automatic logic [2:0] ref_crc(input logic [31:0] v, input int n);
    logic [2:0] c = 3'b111;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = c[2] ^ v[i];
      c = {c[1], c[0] ^ fb, fb};
    end
    return c;
  endfunction

  // preamble 000 1, length bit, addr, code, data, crc
  task automatic build(input bit lng, input logic [2:0] a, input logic [3:0] c, input logic [11:0] d,
                       input bit bad, output logic [31:0] v, output int n);
    logic [31:0] body;
    int nb;
    body = lng ? {13'd0, a, c, d} : {21'd0, a, c, d[3:0]};
    nb = lng ? 19 : 11;
    v = {4'b0001, lng};
    v = (v << nb) | body;
    v = (v << 3) | 32'(ref_crc(body, nb) ^ (bad ? 3'b100 : 3'b000));
    n = 5 + nb + 3;
  endtask

  task automatic send(input logic [31:0] v, input int n, input int stop, input int gap_at,
                      input int gap_per, input int glitch_at);
    for (int i = 0; i < n && i < stop; i++) begin
      if (i == glitch_at) begin
        pulse(v[n-1-i], 8, 16);
        pulse(1'b1, 4, 16);
      end else pulse(v[n-1-i], 8, (i == gap_at) ? gap_per : 32);
    end
  endtask

  task automatic expect_cmd(input string req, input int base, input bit lng, input logic [2:0] a,
                            input logic [3:0] c, input logic [11:0] d);
    check(n_vld == base + 1, req, "cmd count", n_vld - base, 1);
    check(cap_long == lng && cap_addr == a && cap_code == c && cap_data == d, req, "fields",
          {cap_long, cap_addr, cap_code, cap_data}, {lng, a, c, d});
  endtask

  task automatic t_short_own();
    logic [31:0] v; int n; int b = n_vld;
    build(0, 3'b001, 4'h5, 12'h9, 0, v, n);
    send(v, n, 99, -1, 32, -1);
    expect_cmd("R3", b, 0, 3'b001, 4'h5, 12'h009);
  endtask

  task automatic t_long_bcast();
    logic [31:0] v; int n; int b = n_vld;
    build(1, 3'b111, 4'h3, 12'hA5C, 0, v, n);
    send(v, n, 99, -1, 32, -1);
    expect_cmd("R5", b, 1, 3'b111, 4'h3, 12'hA5C);
  endtask

  task automatic t_rejects();
    logic [31:0] v; int n; int b = n_vld;
    build(0, 3'b010, 4'h1, 12'h2, 0, v, n);
    send(v, n, 99, -1, 32, -1);
    check(n_vld == b, "R5", "wrong address ignored", n_vld - b, 0);
    build(1, 3'b001, 4'h7, 12'h123, 1, v, n);
    send(v, n, 99, -1, 32, -1);
    check(n_vld == b, "R4", "bad crc ignored", n_vld - b, 0);
    // two zeros then 1: no start, body pattern never holds three zeros then 1
    v = {14'd0, 18'b00_1_0_111_1011_1101_001};
    send(v, 18, 99, -1, 32, -1);
    check(n_vld == b, "R2", "short preamble ignored", n_vld - b, 0);
  endtask

  task automatic t_glitch();
    logic [31:0] v; int n; int b = n_vld;
    build(0, 3'b001, 4'hC, 12'h6, 0, v, n);
    send(v, n, 99, -1, 32, 9);
    expect_cmd("R1", b, 0, 3'b001, 4'hC, 12'h006);
  endtask

  task automatic t_gap_edge();
    logic [31:0] v; int n; int b = n_vld;
    build(0, 3'b111, 4'h9, 12'hE, 0, v, n);
    send(v, n, 99, 8, 128, -1);
    expect_cmd("R6", b, 0, 3'b111, 4'h9, 12'h00E);
    check(frm_err == 0, "R6", "no error at 128 gap", frm_err, 0);
  endtask

  task automatic t_gap_over();
    logic [31:0] v; int n; int b = n_vld;
    build(0, 3'b001, 4'h4, 12'h3, 0, v, n);
    send(v, n, 10, 8, 129, -1);
    check(n_vld == b, "R6", "129 gap drops frame", n_vld - b, 0);
    check(frm_err == 1, "R7", "error after 129 gap", frm_err, 1);
    pulse(1'b0, 8, 32);
    pulse(1'b0, 8, 32);
  endtask

  task automatic t_abort();
    logic [31:0] v; int n; int b = n_vld;
    build(0, 3'b001, 4'h2, 12'h1, 0, v, n);
    send(v, n, 9, -1, 32, -1);
    repeat (200) @(negedge clk);
    check(frm_err == 0, "R7", "no error before next sync", frm_err, 0);
    pulse(1'b0, 8, 32);
    check(frm_err == 1, "R7", "error at next sync", frm_err, 1);
    check(n_vld == b, "R6", "aborted frame silent", n_vld - b, 0);
    build(0, 3'b001, 4'h6, 12'h5, 0, v, n);
    send(v, n, 99, -1, 32, -1);
    check(frm_err == 0, "R7", "error cleared by new frame", frm_err, 0);
    expect_cmd("R7", b, 0, 3'b001, 4'h6, 12'h005);
  endtask

  task automatic t_pme(input int lead, input int wait_cyc, input bit exp_prog, input string req);
    logic [31:0] v; int n; int b;
    do_reset();
    b = n_vld;
    repeat (wait_cyc) @(negedge clk);
    for (int i = 0; i < lead; i++) pulse(1'b0, 8, 32);
    build(0, 3'b001, 4'hA, 12'h0, 0, v, n);
    send(v, n, 99, -1, 32, -1);
    @(negedge clk);
    check(n_vld == b + 1, req, "entry command decoded", n_vld - b, 1);
    check(prog_mode == exp_prog, req, "prog_mode", prog_mode, exp_prog);
    if (exp_prog) begin
      build(0, 3'b001, 4'h1, 12'h1, 0, v, n);
      send(v, n, 99, -1, 32, -1);
      check(prog_mode == 1, "R8", "prog_mode sticky", prog_mode, 1);
    end
  endtask

  initial begin
    do_reset();
    t_short_own();
    t_long_bcast();
    t_rejects();
    t_glitch();
    t_gap_edge();
    t_gap_over();
    t_abort();
    t_pme(27, 0, 1'b1, "R8");
    t_pme(26, 0, 1'b0, "R9");
    t_pme(40, 3000, 1'b0, "R10");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule